// File: doc/BRIEF.md
# Byte-Wide Parallel Configuration Slave Port

This block is the slave side of a byte-wide parallel configuration interface. On every rising edge of an externally supplied configuration clock it decides, from an active-low select and a single read/write-direction input, whether to take a byte from the shared 8-bit bus, put a readback byte onto it, or do nothing. Incoming bytes are bit-reversed into internal order and emitted on a one-cycle valid/data stream toward the configuration logic. Readback bytes are pulled from an internal valid/ready source, reversed back into pin order and registered onto the bus.

The bidirectional bus is modelled as a separate input, a registered output and an output enable, so the pad ring owns the actual tri-state buffer. A user-mode indication is latched when the configuration logic signals completion. After that point the port stays active only if the persist option input is high. Two sticky flags record a byte that the write stream could not take (overflow) and a read request for which no readback byte was available (underflow).

Top module: `cfgBytePort`

## Requirements
- R1: At a rising edge where the port is active, `selN`=0 and `readNotWrite`=0, and `wrReady`=1, `wrValid` is 1 for exactly the following cycle. In every other cycle `wrValid` is 0.
- R2: Bus pin k maps to internal bit 7-k in both directions: `wrData` equals the bit-reversed bus byte, and `busOut` equals the bit-reversed readback byte. Pin 0 therefore carries the most significant internal bit.
- R3: While the port is active with `selN`=0 and `readNotWrite`=1, `rbReady` equals `rbValid`. After a rising edge with `rbValid`=1, `busOut` holds the bit-reversed `rbData`.
- R4: `busOe` is 1 only while `rstN`=1, the port is active, `selN`=0 and `readNotWrite`=1. Otherwise it is 0, so the bus is tri-stated.
- R5: With `selN`=1 the bus byte, the direction input, `wrReady` and `rbValid` have no effect. `wrValid` stays 0, `rbReady` and `busOe` are 0, and both flags hold their values.
- R6: A read edge with `rbValid`=0 loads 0xFF into `busOut` and sets `unfFlag`. The flag stays set until reset.
- R7: A write edge with `wrReady`=0 drops the byte (no `wrValid`) and sets `ovfFlag`. The flag stays set until reset.
- R8: `userMode` becomes 1 after the first rising edge with `cfgDone`=1 and stays 1 until reset.
- R9: The port is active when `userMode`=0 or `persistEn`=1. While it is inactive, select and direction have no effect: no `wrValid`, `rbReady`=0, `busOe`=0, and flags unchanged.
- R10: `rstN`=0 asynchronously clears `ovfFlag`, `unfFlag`, `userMode`, `wrValid` and `busOut`, and forces `busOe` and `rbReady` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgClk | input | 1 | Configuration clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| selN | input | 1 | Port select, active low |
| readNotWrite | input | 1 | 0 = write byte into device, 1 = read byte out |
| busIn | input | 8 | Bus value seen at the pins (pin index order) |
| busOut | output | 8 | Registered readback byte for the pins |
| busOe | output | 1 | Bus output enable; 0 leaves the bus high impedance |
| persistEn | input | 1 | Keep the port active after configuration completes |
| cfgDone | input | 1 | Configuration completion pulse or level |
| wrValid | output | 1 | Accepted byte valid, one cycle per byte |
| wrData | output | 8 | Accepted byte in internal bit order |
| wrReady | input | 1 | Downstream can take a byte at this edge |
| rbValid | input | 1 | Readback source has a byte |
| rbData | input | 8 | Readback byte in internal bit order |
| rbReady | output | 1 | Readback byte consumed at this edge |
| userMode | output | 1 | Configuration has completed |
| ovfFlag | output | 1 | Sticky: a written byte was dropped |
| unfFlag | output | 1 | Sticky: a read found no readback byte |

## Verification
Every cycle, the embedded assertions check these properties:
- a deselected edge never yields a write strobe;
- the output enable is up whenever a readback byte is consumed;
- an emitted byte is the bit reversal of the bus one edge earlier;
- the two flags and the user-mode bit never fall without reset.

Some behaviour shows only in the bench scenarios:
- that 0xFF appears exactly on starved reads;
- that a refused write really disappears;
- that the persist input decides whether the port goes quiet in user mode;
- that an asynchronous reset mid-transfer clears state between edges.

// File: rtl/cfgBytePortPkg.sv
package cfgBytePortPkg;
  typedef struct packed {
    logic keepByte;   // write accepted and forwarded
    logic dropByte;   // write refused by downstream
    logic giveByte;   // read served from readback source
    logic starveByte; // read with nothing to serve
  } portStrobe_t;
endpackage

// File: rtl/cfgBytePortCtrl.sv
module cfgBytePortCtrl
  import cfgBytePortPkg::*;
(
  input  logic        cfgClk,
  input  logic        rstN,
  input  logic        selN,
  input  logic        readNotWrite,
  input  logic        persistEn,
  input  logic        cfgDone,
  input  logic        wrReady,
  input  logic        rbValid,
  output portStrobe_t strobe,
  output logic        busOe,
  output logic        rbReady,
  output logic        userMode,
  output logic        ovfFlag,
  output logic        unfFlag
);
  logic portActive;
  logic readReq;
  logic writeReq;

  assign portActive = !userMode || persistEn;
  assign readReq    = rstN && portActive && !selN && readNotWrite;
  assign writeReq   = rstN && portActive && !selN && !readNotWrite;

  always_comb begin
    strobe.keepByte   = writeReq && wrReady;
    strobe.dropByte   = writeReq && !wrReady;
    strobe.giveByte   = readReq && rbValid;
    strobe.starveByte = readReq && !rbValid;
  end

  assign busOe   = readReq;
  assign rbReady = readReq && rbValid;

  always_ff @(posedge cfgClk or negedge rstN) begin
    if (!rstN) begin
      userMode <= 1'b0;
      ovfFlag  <= 1'b0;
      unfFlag  <= 1'b0;
    end else begin
      if (cfgDone)           userMode <= 1'b1;
      if (strobe.dropByte)   ovfFlag  <= 1'b1;
      if (strobe.starveByte) unfFlag  <= 1'b1;
    end
  end

  // R7
  ovf_sticky_chk: assert property (@(posedge cfgClk) disable iff (!rstN)
    ovfFlag |=> ovfFlag);
  // R6
  unf_sticky_chk: assert property (@(posedge cfgClk) disable iff (!rstN)
    unfFlag |=> unfFlag);
  // R8
  user_mode_hold_chk: assert property (@(posedge cfgClk) disable iff (!rstN)
    userMode |=> userMode);
endmodule

// File: rtl/cfgBytePortData.sv
module cfgBytePortData
  import cfgBytePortPkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             cfgClk,
  input  logic             rstN,
  input  portStrobe_t      strobe,
  input  logic [BUS_W-1:0] busIn,
  input  logic [BUS_W-1:0] rbData,
  output logic             wrValid,
  output logic [BUS_W-1:0] wrData,
  output logic [BUS_W-1:0] busOut
);
  localparam int TOP = BUS_W - 1;

  logic [BUS_W-1:0] revIn;
  logic [BUS_W-1:0] revRb;

  for (genvar i = 0; i < BUS_W; i++) begin : g_swap
    assign revIn[i] = busIn[TOP-i];
    assign revRb[i] = rbData[TOP-i];
  end

  always_ff @(posedge cfgClk or negedge rstN) begin
    if (!rstN) begin
      wrValid <= 1'b0;
      wrData  <= '0;
      busOut  <= '0;
    end else begin
      wrValid <= strobe.keepByte;
      if (strobe.keepByte)        wrData <= revIn;
      if (strobe.giveByte)        busOut <= revRb;
      else if (strobe.starveByte) busOut <= '1;
    end
  end

  // R2
  wr_order_chk: assert property (@(posedge cfgClk) disable iff (!rstN)
    strobe.keepByte |=> (wrData[TOP] == $past(busIn[0]) && wrData[0] == $past(busIn[TOP])));
  // R6
  starve_fill_chk: assert property (@(posedge cfgClk) disable iff (!rstN)
    strobe.starveByte |=> (busOut == '1));
endmodule

// File: rtl/cfgBytePort.sv
module cfgBytePort
  import cfgBytePortPkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             cfgClk,
  input  logic             rstN,
  input  logic             selN,
  input  logic             readNotWrite,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busOut,
  output logic             busOe,
  input  logic             persistEn,
  input  logic             cfgDone,
  output logic             wrValid,
  output logic [BUS_W-1:0] wrData,
  input  logic             wrReady,
  input  logic             rbValid,
  input  logic [BUS_W-1:0] rbData,
  output logic             rbReady,
  output logic             userMode,
  output logic             ovfFlag,
  output logic             unfFlag
);
  portStrobe_t strobe;

  cfgBytePortCtrl u_ctrl (
    .cfgClk(cfgClk), .rstN(rstN), .selN(selN), .readNotWrite(readNotWrite),
    .persistEn(persistEn), .cfgDone(cfgDone), .wrReady(wrReady),
    .rbValid(rbValid), .strobe(strobe), .busOe(busOe), .rbReady(rbReady),
    .userMode(userMode), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  cfgBytePortData #(.BUS_W(BUS_W)) u_data (
    .cfgClk(cfgClk), .rstN(rstN), .strobe(strobe), .busIn(busIn),
    .rbData(rbData), .wrValid(wrValid), .wrData(wrData), .busOut(busOut)
  );

  // R5
  desel_quiet_chk: assert property (@(posedge cfgClk) disable iff (!rstN)
    $past(selN) |-> !wrValid);
  // R4
  pop_needs_oe_chk: assert property (@(posedge cfgClk) disable iff (!rstN)
    rbReady |-> (busOe && !selN && readNotWrite));
  // R1
  write_dir_chk: assert property (@(posedge cfgClk) disable iff (!rstN)
    wrValid |-> $past(!readNotWrite && wrReady));
endmodule

// File: tb/cfgBytePort_tb.sv
module cfgBytePort_tb;
  logic       cfgClk = 1'b0;
  logic       rstN = 1'b0;
  logic       selN = 1'b1, readNotWrite = 1'b0, persistEn = 1'b0, cfgDone = 1'b0;
  logic [7:0] busIn = '0, rbData = '0, busOut, wrData;
  logic       busOe, wrValid, wrReady = 1'b0, rbValid = 1'b0, rbReady;
  logic       userMode, ovfFlag, unfFlag;

  int total = 0;
  int bad = 0;
  bit mUser = 0, mOvf = 0, mUnf = 0;

  always #10 cfgClk = ~cfgClk;

  cfgBytePort u_dut (
    .cfgClk(cfgClk), .rstN(rstN), .selN(selN), .readNotWrite(readNotWrite),
    .busIn(busIn), .busOut(busOut), .busOe(busOe), .persistEn(persistEn),
    .cfgDone(cfgDone), .wrValid(wrValid), .wrData(wrData), .wrReady(wrReady),
    .rbValid(rbValid), .rbData(rbData), .rbReady(rbReady), .userMode(userMode),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge: drives, checks combinational outputs, waits one edge, checks registers.
  task automatic cyc(input bit s, input bit rw, input logic [7:0] b, input bit rdy,
                     input bit rv, input logic [7:0] rd, input bit done);
    bit act, rdOp, wrOp;
    selN = s; readNotWrite = rw; busIn = b; wrReady = rdy;
    rbValid = rv; rbData = rd; cfgDone = done;
    #1;
    act  = !mUser || persistEn;
    rdOp = act && !s && rw;
    wrOp = act && !s && !rw;
    chk("R4 busOe", {7'd0, busOe}, {7'd0, rdOp});
    chk("R3/R5/R9 rbReady", {7'd0, rbReady}, {7'd0, rdOp && rv});
    @(negedge cfgClk);
    mOvf  = mOvf || (wrOp && !rdy);
    mUnf  = mUnf || (rdOp && !rv);
    mUser = mUser || done;
    chk("R1/R7/R9 wrValid", {7'd0, wrValid}, {7'd0, wrOp && rdy});
    if (wrOp && rdy) chk("R2 wrData", wrData, rev8(b));
    if (rdOp) chk("R3/R6 busOut", busOut, rv ? rev8(rd) : 8'hFF);
    chk("R7 ovfFlag", {7'd0, ovfFlag}, {7'd0, mOvf});
    chk("R6 unfFlag", {7'd0, unfFlag}, {7'd0, mUnf});
    chk("R8 userMode", {7'd0, userMode}, {7'd0, mUser});
  endtask

  task automatic randRun(input int n, input int donePct);
    for (int k = 0; k < n; k++) begin
      cyc($urandom_range(0, 3) == 0, $urandom_range(0, 1), 8'($urandom),
          $urandom_range(0, 4) != 0, $urandom_range(0, 4) != 0, 8'($urandom),
          $urandom_range(0, 99) < donePct);
    end
  endtask

  task automatic doReset();
    @(negedge cfgClk); #3;
    rstN = 1'b0; #2;
    mUser = 0; mOvf = 0; mUnf = 0;
    // R10 asynchronous clear, checked between edges
    chk("R10 busOe", {7'd0, busOe}, 8'd0);
    chk("R10 rbReady", {7'd0, rbReady}, 8'd0);
    chk("R10 flags", {5'd0, ovfFlag, unfFlag, userMode}, 8'd0);
    chk("R10 wrValid", {7'd0, wrValid}, 8'd0);
    chk("R10 busOut", busOut, 8'd0);
    @(negedge cfgClk);
    rstN = 1'b1;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    selN = 1'b0; readNotWrite = 1'b1; rbValid = 1'b1; #5;
    // R10 state while held in reset, even with a read requested
    chk("R10 busOe in reset", {7'd0, busOe}, 8'd0);
    chk("R10 rbReady in reset", {7'd0, rbReady}, 8'd0);
    chk("R10 flags in reset", {5'd0, ovfFlag, unfFlag, userMode}, 8'd0);
    chk("R10 busOut in reset", busOut, 8'd0);
    @(negedge cfgClk); rstN = 1'b1;
    // R2 directed bit order
    cyc(0, 0, 8'h80, 1, 0, 8'h00, 0);
    cyc(0, 0, 8'h01, 1, 0, 8'h00, 0);
    cyc(0, 0, 8'h0F, 1, 0, 8'h00, 0);
    cyc(0, 1, 8'h00, 1, 1, 8'h80, 0);
    cyc(0, 1, 8'h00, 1, 1, 8'h3C, 0);
    // R5 deselected with junk everywhere
    cyc(1, 0, 8'hA5, 0, 0, 8'h00, 0);
    cyc(1, 1, 8'h5A, 0, 0, 8'h00, 0);
    // R6 underflow, R7 overflow
    cyc(0, 1, 8'h00, 1, 0, 8'h11, 0);
    cyc(0, 0, 8'hC3, 0, 1, 8'h00, 0);
    cyc(0, 0, 8'h42, 1, 1, 8'h00, 0);
    randRun(400, 0);
    // R9 persist on: port survives user mode
    doReset();
    persistEn = 1'b1;
    cyc(0, 0, 8'h12, 1, 1, 8'h00, 1);
    randRun(400, 2);
    // R9 persist off: port goes quiet after user mode
    doReset();
    persistEn = 1'b0;
    randRun(100, 0);
    cyc(1, 0, 8'h00, 1, 1, 8'h00, 1);
    cyc(0, 1, 8'h00, 1, 0, 8'h00, 0);
    cyc(0, 0, 8'hFF, 0, 1, 8'h00, 0);
    randRun(300, 1);
    doReset();
    randRun(200, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule